// File: doc/BRIEF.md
# Scratchpad Fetch-and-Add Command Engine

The engine takes one 64-bit command word at a time that asks for an atomic fetch-and-add on a small internal array of counters. It does not return the old counter value on a response channel. It writes that value into a local scratchpad, at a word index carried in the command, as a single-cycle write strobe. The command also carries the operand width (8, 16, 32 or 64 bits), a signed 22-bit increment, the byte address of the counter and a flag that makes the update wait for an external tag-switch completion signal.

If the wait flag is set, the engine holds the command until `tag_sw_done` is seen high. If that does not happen within `TAG_TIMEOUT` cycles, it abandons the update and writes a word whose top bit marks the result as invalid. A command whose length field is not 1 is rejected with an error pulse. Only one command is in flight; `cmd_ready` is low while it is being processed.

Top module: `scratch_fadd_engine`

## Requirements
- R1: After reset `cmd_ready` is 1, `sp_we` and `cmd_err` are 0, and every counter byte is zero.
- R2: Command fields: bits 63:56 are the scratchpad word index (byte address divided by 8), driven on `sp_addr`; bits 55:48 are the length; bits 35:14 are the signed increment; bit 13 is the wait flag; bits 12:11 are the size (0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit); bits 10:0 are the counter byte address, of which only the low log2(REG_BYTES) bits are used (default 8 bits, so 0x703 names the same byte as 0x003).
- R3: A valid write carries the counter value from before the add. The counter then becomes old value plus the sign-extended increment, truncated to the operand width (wrapping).
- R4: Counters are little-endian bytes. A 16-bit access ignores address bit 0, a 32-bit access ignores bits 1:0 and a 64-bit access ignores bits 2:0. An access changes only the bytes of its own width.
- R5: Without the wait flag, `sp_we` is high for exactly one cycle: the cycle that follows the one in which the command was accepted.
- R6: From the cycle after acceptance, `cmd_ready` stays low until the write or error cycle has ended, and it returns high in the next cycle.
- R7: With the wait flag set, the write is a valid result (bit 63 clear), issued the cycle after `tag_sw_done` is sampled high.
- R8: With the wait flag set and `tag_sw_done` low throughout, the write comes exactly TAG_TIMEOUT+1 cycles after acceptance. It carries data 0x8000_0000_0000_0000 and the counter is not updated.
- R9: A command whose length is not 1 produces a one-cycle `cmd_err` pulse in the cycle after acceptance. It produces no scratchpad write and does not update the counter.
- R10: The written word is the old value sign-extended to 64 bits with bit 63 forced to 0. For a 64-bit operand, old bit 63 is not delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command word is offered |
| cmd_ready | output | 1 | The engine is idle and takes the offered command |
| cmd_word | input | 64 | Command word |
| tag_sw_done | input | 1 | Tag switch has completed (used by waiting commands) |
| sp_we | output | 1 | Scratchpad write strobe, one cycle |
| sp_addr | output | 8 | Scratchpad word index |
| sp_data | output | 64 | Scratchpad write data |
| cmd_err | output | 1 | One-cycle pulse: command rejected |

## Verification
The hardest situations to reach are the tag-wait window edges: the timeout, and a completion that arrives several cycles into the wait. To reach the timeout, the stimulus holds `tag_sw_done` low for the whole window and counts cycles from acceptance until the invalid write appears. It then re-reads the counter to prove it was untouched. Late completion is produced by raising `tag_sw_done` a fixed number of cycles after the command is offered. A scoreboard checks every write against a byte-level model, including sign extension across lane offsets and 64-bit values with bit 63 set.

// File: rtl/sfae_pkg.sv
package sfae_pkg;
  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2,
    SZ_D = 2'd3
  } opsize_e;

  typedef struct packed {
    logic [7:0]  dst;
    logic [7:0]  len;
    logic [21:0] inc;
    logic        twait;
    opsize_e     size;
    logic [10:0] raddr;
  } cmd_t;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_WAIT = 3'd1,
    S_EXEC = 3'd2,
    S_TOUT = 3'd3,
    S_REJ  = 3'd4
  } state_e;
endpackage

// File: rtl/sfae_cmd_decode.sv
module sfae_cmd_decode
  import sfae_pkg::*;
(
  input  logic [63:0] word,
  output cmd_t        cmd
);
  logic unused_gap;
  assign unused_gap = ^word[47:36];

  always_comb begin
    cmd.dst   = word[63:56];
    cmd.len   = word[55:48];
    cmd.inc   = word[35:14];
    cmd.twait = word[13];
    cmd.size  = opsize_e'(word[12:11]);
    cmd.raddr = word[10:0];
  end
endmodule

// File: rtl/sfae_lane_alu.sv
module sfae_lane_alu
  import sfae_pkg::*;
(
  input  logic [63:0] word_in,
  input  logic [2:0]  off,
  input  opsize_e     size,
  input  logic [21:0] inc,
  output logic [63:0] old_sx,
  output logic [63:0] word_out
);
  logic [2:0]  lane;
  logic [5:0]  sh;
  logic [63:0] mask;
  logic [63:0] raw;
  logic [63:0] sum;

  always_comb begin
    case (size)
      SZ_B: begin lane = off;               mask = 64'h0000_0000_0000_00FF; end
      SZ_H: begin lane = {off[2:1], 1'b0};  mask = 64'h0000_0000_0000_FFFF; end
      SZ_W: begin lane = {off[2], 2'b00};   mask = 64'h0000_0000_FFFF_FFFF; end
      default: begin lane = 3'd0;           mask = '1; end
    endcase
    sh  = {lane, 3'b000};
    raw = word_in >> sh;
    sum = raw + {{42{inc[21]}}, inc};
    case (size)
      SZ_B:    old_sx = {{56{raw[7]}},  raw[7:0]};
      SZ_H:    old_sx = {{48{raw[15]}}, raw[15:0]};
      SZ_W:    old_sx = {{32{raw[31]}}, raw[31:0]};
      default: old_sx = raw;
    endcase
    word_out = (word_in & ~(mask << sh)) | ((sum & mask) << sh);
  end
endmodule

// File: rtl/sfae_regfile.sv
module sfae_regfile #(
  parameter int WORDS = 32,
  localparam int IW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] idx,
  output logic [63:0]   rd_data,
  input  logic          we,
  input  logic [63:0]   wr_data
);
  logic [63:0] mem [WORDS];

  assign rd_data = mem[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (we) begin
      mem[idx] <= wr_data;
    end
  end
endmodule

// File: rtl/sfae_tag_timer.sv
module sfae_tag_timer #(
  parameter int LIMIT = 16,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  logic [CW-1:0] cnt_q, cnt_d;

  assign expire = run && (cnt_q == CW'(LIMIT - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (!run)        cnt_d = '0;
    else if (!expire) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R8: window counter never passes its limit
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(LIMIT));
endmodule

// File: rtl/scratch_fadd_engine.sv
module scratch_fadd_engine
  import sfae_pkg::*;
#(
  parameter int REG_BYTES   = 256,
  parameter int TAG_TIMEOUT = 16,
  localparam int AW    = $clog2(REG_BYTES),
  localparam int WORDS = REG_BYTES / 8,
  localparam int IW    = AW - 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [63:0] cmd_word,
  input  logic        tag_sw_done,
  output logic        sp_we,
  output logic [7:0]  sp_addr,
  output logic [63:0] sp_data,
  output logic        cmd_err
);
  state_e      state_q, state_d;
  cmd_t        cmd_d, cmd_q;
  logic        accept;
  logic        expire;
  logic [63:0] rd_word, wr_word, old_sx;
  logic        unused_hi;

  sfae_cmd_decode u_dec (.word(cmd_word), .cmd(cmd_d));

  assign cmd_ready = (state_q == S_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign unused_hi = ^cmd_q.raddr[10:AW];

  // next state
  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE: if (cmd_valid) begin
                if (cmd_d.len != 8'd1) state_d = S_REJ;
                else if (cmd_d.twait)  state_d = S_WAIT;
                else                   state_d = S_EXEC;
              end
      S_WAIT: if (tag_sw_done) state_d = S_EXEC;
              else if (expire) state_d = S_TOUT;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (accept) cmd_q <= cmd_d;
  end

  sfae_tag_timer #(.LIMIT(TAG_TIMEOUT)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(state_q == S_WAIT), .expire(expire));

  sfae_regfile #(.WORDS(WORDS)) u_rf (
    .clk(clk), .rst_n(rst_n), .idx(cmd_q.raddr[AW-1:3]),
    .rd_data(rd_word), .we(state_q == S_EXEC), .wr_data(wr_word));

  sfae_lane_alu u_alu (
    .word_in(rd_word), .off(cmd_q.raddr[2:0]), .size(cmd_q.size),
    .inc(cmd_q.inc), .old_sx(old_sx), .word_out(wr_word));

  // outputs
  assign sp_we   = (state_q == S_EXEC) || (state_q == S_TOUT);
  assign sp_addr = cmd_q.dst;
  assign sp_data = (state_q == S_TOUT) ? {1'b1, 63'd0} : {1'b0, old_sx[62:0]};
  assign cmd_err = (state_q == S_REJ);

  // R6: busy after accepting
  p_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !cmd_ready);
  // R5: immediate command writes next cycle to the commanded index
  p_write_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_d.len == 8'd1 && !cmd_d.twait) |=>
      (sp_we && !sp_data[63] && sp_addr == $past(cmd_word[63:56])));
  // R5: strobe lasts a single cycle
  p_one_shot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sp_we |=> !sp_we);
  // R9: bad length rejected without a write
  p_reject_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_d.len != 8'd1) |=> (cmd_err && !sp_we));
  // R9: error and write never coincide
  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_err && sp_we));
  // R8: invalid word only after a cycle without tag completion
  p_invalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_we && sp_data[63]) |-> $past(!tag_sw_done));
endmodule

// File: tb/scratch_fadd_engine_test.sv
module scratch_fadd_engine_test;
  localparam int TOUT = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [63:0] cmd_word;
  logic        tag_sw_done;
  logic        sp_we;
  logic [7:0]  sp_addr;
  logic [63:0] sp_data;
  logic        cmd_err;

  always #2 clk = ~clk;

  scratch_fadd_engine #(.REG_BYTES(256), .TAG_TIMEOUT(TOUT)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_word(cmd_word), .tag_sw_done(tag_sw_done), .sp_we(sp_we),
    .sp_addr(sp_addr), .sp_data(sp_data), .cmd_err(cmd_err));

  int tests = 0;
  int fails = 0;
  logic [7:0]  model [256];
  logic [71:0] expq [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [7:0] dst, input logic [7:0] len,
      input logic [21:0] inc, input bit tw, input logic [1:0] sz, input logic [10:0] ad);
    return {dst, len, 12'd0, inc, tw, sz, ad};
  endfunction

  // model: returns expected written word and applies the add
  function automatic logic [63:0] model_fadd(input logic [1:0] sz, input logic [10:0] ad,
                                             input logic [21:0] inc, input bit apply);
    int nb;
    int base;
    logic [63:0] old;
    logic [63:0] nv;
    logic [63:0] sx;
    nb   = 1 << sz;
    base = int'(ad[7:0]) & ~(nb - 1);
    old  = '0;
    for (int b = 0; b < nb; b++) old[8*b +: 8] = model[base + b];
    nv = old + {{42{inc[21]}}, inc};
    if (apply) for (int b = 0; b < nb; b++) model[base + b] = nv[8*b +: 8];
    sx = old;
    if (nb < 8 && old[8*nb-1]) for (int k = 8*nb; k < 64; k++) sx[k] = 1'b1;
    sx[63] = 1'b0;
    return sx;
  endfunction

  task automatic issue(input logic [63:0] w, input bit exp_err, input bit exp_tout,
                       input string req);
    logic [63:0] e;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    if (w[55:48] == 8'd1) begin
      if (exp_tout) e = 64'h8000_0000_0000_0000;
      else          e = model_fadd(w[12:11], w[10:0], w[35:14], 1'b1);
      expq.push_back({w[63:56], e});
    end
    cmd_valid = 1'b1;
    cmd_word  = w;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(cmd_ready == 1'b0, "R6", "ready low after accept", 64'(cmd_ready), 64'd0);
    if (exp_err)
      chk(cmd_err == 1'b1 && sp_we == 1'b0, "R9", "err pulse, no write",
          {cmd_err, sp_we}, 64'd2);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && sp_we) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R5", "unexpected write", sp_data, 64'd0);
      end else begin
        logic [71:0] it;
        it = expq.pop_front();
        chk(sp_addr == it[71:64], "R2", "scratch index", 64'(sp_addr), 64'(it[71:64]));
        chk(sp_data == it[63:0], "R3", "write data", sp_data, it[63:0]);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "R5", "watchdog expired", 64'd0, 64'd1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 8'd0;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_word = '0; tag_sw_done = 1'b0;
    repeat (3) @(negedge clk);
    chk(cmd_ready == 1'b1 && sp_we == 1'b0 && cmd_err == 1'b0, "R1", "reset outputs",
        {cmd_ready, sp_we, cmd_err}, 64'd4);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset contents zero, R3 basic add
    issue(mk(8'h01, 8'd1, 22'd5, 1'b0, 2'd0, 11'h003), 1'b0, 1'b0, "R3");
    issue(mk(8'h02, 8'd1, -22'sd7, 1'b0, 2'd0, 11'h003), 1'b0, 1'b0, "R3");
    issue(mk(8'h03, 8'd1, 22'd0, 1'b0, 2'd0, 11'h003), 1'b0, 1'b0, "R10");
    // R2 high address bits ignored
    issue(mk(8'h04, 8'd1, 22'd1, 1'b0, 2'd0, 11'h703), 1'b0, 1'b0, "R2");
    // R4 alignment of sizes
    issue(mk(8'h05, 8'd1, 22'h1234, 1'b0, 2'd1, 11'h011), 1'b0, 1'b0, "R4");
    issue(mk(8'h06, 8'd1, 22'd0, 1'b0, 2'd1, 11'h010), 1'b0, 1'b0, "R4");
    issue(mk(8'h07, 8'd1, 22'h1FFFFF, 1'b0, 2'd2, 11'h016), 1'b0, 1'b0, "R4");
    issue(mk(8'h08, 8'd1, 22'h200000, 1'b0, 2'd2, 11'h014), 1'b0, 1'b0, "R3");
    issue(mk(8'h09, 8'd1, 22'd0, 1'b0, 2'd3, 11'h010), 1'b0, 1'b0, "R4");
    issue(mk(8'h0A, 8'd1, 22'd0, 1'b0, 2'd3, 11'h007), 1'b0, 1'b0, "R4");
    // R3 8-bit wrap into negative
    issue(mk(8'h0B, 8'd1, 22'h00007F, 1'b0, 2'd0, 11'h025), 1'b0, 1'b0, "R3");
    issue(mk(8'h0C, 8'd1, 22'd1, 1'b0, 2'd0, 11'h025), 1'b0, 1'b0, "R3");
    issue(mk(8'h0D, 8'd1, 22'd0, 1'b0, 2'd0, 11'h025), 1'b0, 1'b0, "R3");
    // R10 64-bit all ones: bit 63 dropped
    issue(mk(8'h0E, 8'd1, -22'sd1, 1'b0, 2'd3, 11'h038), 1'b0, 1'b0, "R10");
    issue(mk(8'h0F, 8'd1, 22'd0, 1'b0, 2'd3, 11'h03F), 1'b0, 1'b0, "R10");

    // R5 exact single-cycle strobe timing
    issue(mk(8'h10, 8'd1, 22'd2, 1'b0, 2'd1, 11'h040), 1'b0, 1'b0, "R5");
    chk(sp_we == 1'b1, "R5", "write in cycle after accept", 64'(sp_we), 64'd1);
    @(negedge clk);
    chk(sp_we == 1'b0 && cmd_ready == 1'b1, "R6", "strobe ends, ready back",
        {sp_we, cmd_ready}, 64'd1);

    // R7 tag wait with completion already present
    tag_sw_done = 1'b1;
    issue(mk(8'h20, 8'd1, 22'd9, 1'b1, 2'd2, 11'h048), 1'b0, 1'b0, "R7");
    chk(sp_we == 1'b0, "R7", "no write during wait cycle", 64'(sp_we), 64'd0);
    @(negedge clk);
    chk(sp_we == 1'b1, "R7", "write after done sampled", 64'(sp_we), 64'd1);
    tag_sw_done = 1'b0;
    // R7 late completion
    fork
      issue(mk(8'h21, 8'd1, 22'd3, 1'b1, 2'd2, 11'h048), 1'b0, 1'b0, "R7");
      begin repeat (6) @(negedge clk); tag_sw_done = 1'b1; end
    join
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    tag_sw_done = 1'b0;

    // R8 timeout: exact latency, invalid word, no update
    issue(mk(8'h30, 8'd1, 22'd100, 1'b1, 2'd2, 11'h048), 1'b0, 1'b1, "R8");
    for (int n = 1; n <= TOUT; n++) begin
      @(negedge clk);
      chk(sp_we == (n == TOUT), "R8", "timeout write latency", 64'(sp_we), 64'(n == TOUT));
    end
    issue(mk(8'h31, 8'd1, 22'd0, 1'b0, 2'd2, 11'h048), 1'b0, 1'b0, "R8");

    // R9 bad lengths, then counter unchanged
    issue(mk(8'h40, 8'd0, 22'd50, 1'b0, 2'd0, 11'h003), 1'b1, 1'b0, "R9");
    issue(mk(8'h41, 8'd2, 22'd50, 1'b0, 2'd0, 11'h003), 1'b1, 1'b0, "R9");
    issue(mk(8'h42, 8'd1, 22'd0, 1'b0, 2'd0, 11'h003), 1'b0, 1'b0, "R9");

    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "R5", "all expected writes seen", 64'(expq.size()), 64'd0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule